// File: doc/BRIEF.md
# CardBus Wake and Powerdown Event Controller

This block keeps the power-management enable and wake status bits of a PCI function in step with the event and mask registers that a CardBus card exposes. Requests for wakeup and powerdown arrive from logic elsewhere in the chip. Each request is first qualified by a local enable input. The block then latches the qualified requests into sticky status bits. It drives one registered wake request output per bus mode and one registered interrupt line.

Software reaches the registers through a single-cycle write/read port. The port has per-byte write strobes, and every status bit is cleared by writing a one to it. Two inputs set the operating mode. The first selects CardBus or PCI operation. The second turns on the CardBus-side event gating.

When the gating is off, which is the default, CardBus wake behaviour is identical to PCI wake behaviour and only the output pin differs. When the gating is on, the mask and event registers decide whether a wake request or an interrupt reaches its output.

Top module: `cb_wake_ctrl`

Register layout (16-bit data, 2-bit address; bits not listed read as 0 and ignore writes):
- address 0, power control: bit 0 `pm_enable` (read/write), bit 1 `pm_status` (write one to clear)
- address 1, card events: bit 4 `ev_wake` (write one to clear), bit 15 `ev_pdown` (write one to clear)
- address 2, card masks: bit 4 `mk_wake`, bit 14 `mk_wkup`, bit 15 `mk_pdown` (all read/write)
- address 3: reads 0

## Requirements
- R1: After reset every register bit reads 0 at addresses 0, 1 and 2, and `pme_req`, `sysevt_req` and `card_int` are 0.
- R2: A write to address 0 with strobe lane 0 set stores data bit 0 into `pm_enable` and copies the same value into both `mk_wake` (address 2 bit 4) and `mk_wkup` (address 2 bit 14).
- R3: Writing address 2 changes only the mask bits and never changes `pm_enable`.
- R4: When `pm_enable` is already 1 and a qualified wake request (`wake_req` and `wake_local_en` both 1) is seen at a clock edge, that edge sets both `pm_status` and `ev_wake`.
- R5: Writing 1 to `pm_status` (address 0 bit 1) or to `ev_wake` (address 1 bit 4) clears both bits. Writing 0 to either bit leaves both unchanged, so the two bits always read equal.
- R6: If a qualified wake request arrives in the same cycle as the clearing write of R5, the bits stay set.
- R7: When gating is inactive (PCI mode, or `stsreg_en` = 0), the wake output of the selected mode is 1 one cycle after `pm_enable` and `pm_status` are both 1, and it returns to 0 one cycle after either bit clears.
- R8: In CardBus mode with `stsreg_en` = 1, `sysevt_req` is 1 one cycle after `mk_wake`, `mk_wkup` and `ev_wake` are all 1, and it is 0 otherwise.
- R9: `pme_req` can be 1 only when the previous cycle had `mode_cardbus` = 0, and `sysevt_req` only when the previous cycle had `mode_cardbus` = 1. The two outputs are never 1 together.
- R10: A qualified powerdown request (`pdown_req` and `pdown_local_en` both 1) sets the sticky bit `ev_pdown`. In CardBus mode with `stsreg_en` = 1, `card_int` is 1 one cycle after `mk_pdown` and `ev_pdown` are both 1. Otherwise `card_int` follows the qualified powerdown request one cycle later.
- R11: A byte lane whose write strobe is 0 is left unchanged by a write. Lane 0 holds bits 7..0 and lane 1 holds bits 15..8.
- R12: A wake request with `wake_local_en` = 0, or a powerdown request with `pdown_local_en` = 0, sets no status bit and drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (2) | Register address for write and read |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_wstrb | input | DATA_W/8 (2) | Per-byte write enables |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr`, combinational |
| mode_cardbus | input | 1 | 1 selects CardBus operation, 0 selects PCI |
| stsreg_en | input | 1 | 1 turns on CardBus event and mask gating |
| wake_req | input | 1 | Internal wakeup request |
| wake_local_en | input | 1 | Local enable that qualifies `wake_req` |
| pdown_req | input | 1 | Internal powerdown request |
| pdown_local_en | input | 1 | Local enable that qualifies `pdown_req` |
| pme_req | output | 1 | Registered PCI wake request, active high |
| sysevt_req | output | 1 | Registered CardBus status-change wake request, active high |
| card_int | output | 1 | Registered interrupt request, active high |

## Verification
Several properties are checked on every cycle. The two wake status bits must always be equal. The wake outputs must never be active together and must match the previous cycle's mode. A pending qualified wake must set the status bits. An enable write must leave both wake mask bits equal to the enable, and a mask write must leave the enable stable. Gated CardBus outputs must be backed by the previous cycle's mask and event state. Other behaviour can only be shown by the bench's scenarios: byte-lane isolation, writes of zero to status bits, the exact read-back values, and the one-cycle output latency in bypass and gated modes. The bench checks these against a behavioural model, and a random phase mixes modes, writes and requests.

// File: rtl/cbw_pkg.sv
`timescale 1ns/1ps
package cbw_pkg;

   // Architectural state shared between the register file and the output stage
   typedef struct packed {
      logic pme_en;
      logic pme_sts;
      logic gwake_evt;
      logic pdn_evt;
      logic msk_gwake;
      logic msk_wkup;
      logic msk_pdn;
   } cbw_state_t;

   typedef enum logic [1:0] {
      SEL_PM   = 2'd0,
      SEL_EVT  = 2'd1,
      SEL_MSK  = 2'd2,
      SEL_NONE = 2'd3
   } cbw_sel_e;

endpackage

// File: rtl/cbw_sticky.sv
`timescale 1ns/1ps
// One sticky event bit: set by an event, cleared by a write of one.
module cbw_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q_o <= 1'b0;
            else if (set_i)  q_o <= 1'b1;
            else if (clr_i)  q_o <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q_o <= 1'b0;
            else if (clr_i)  q_o <= 1'b0;
            else if (set_i)  q_o <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/cbw_regs.sv
`timescale 1ns/1ps
// Register file: enable/status, event and mask bits with cross coupling.
module cbw_regs
   import cbw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int ADDR_PM   = 0,
   parameter int ADDR_EVT  = 1,
   parameter int ADDR_MSK  = 2,
   parameter int PMEN_BIT  = 0,
   parameter int PMSTS_BIT = 1,
   parameter int GWAKE_BIT = 4,
   parameter int WKUP_BIT  = 14,
   parameter int PDN_BIT   = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [DATA_W/8-1:0] reg_wstrb,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                wake_q,
   input  logic                pdn_q,
   output cbw_state_t          st_o
);

   localparam int STRB_W    = DATA_W / 8;
   localparam int LN_PMEN   = PMEN_BIT / 8;
   localparam int LN_PMSTS  = PMSTS_BIT / 8;
   localparam int LN_GWAKE  = GWAKE_BIT / 8;
   localparam int LN_PDN    = PDN_BIT / 8;
   localparam int N_MSK     = 3;
   localparam int MSK_POS    [N_MSK] = '{GWAKE_BIT, WKUP_BIT, PDN_BIT};
   localparam bit MSK_FOLLOW [N_MSK] = '{1'b1, 1'b1, 1'b0};

   cbw_sel_e         sel;
   logic             pmen_we;
   logic             pmen_val;
   logic             pmen_q;
   logic             wake_clr;
   logic             wake_set;
   logic             pdn_clr;
   logic             sts_q;
   logic             gwake_q;
   logic             pdn_evt_q;
   logic [N_MSK-1:0] msk_q;
   logic             unused_bits;

   // Address decode
   always_comb begin
      if (reg_addr == ADDR_W'(ADDR_PM))       sel = SEL_PM;
      else if (reg_addr == ADDR_W'(ADDR_EVT)) sel = SEL_EVT;
      else if (reg_addr == ADDR_W'(ADDR_MSK)) sel = SEL_MSK;
      else                                    sel = SEL_NONE;
   end

   // Write qualifiers
   always_comb begin
      pmen_we  = reg_wr && (sel == SEL_PM) && reg_wstrb[LN_PMEN];
      pmen_val = reg_wdata[PMEN_BIT];
      wake_clr = (reg_wr && (sel == SEL_PM)  && reg_wstrb[LN_PMSTS] && reg_wdata[PMSTS_BIT])
              || (reg_wr && (sel == SEL_EVT) && reg_wstrb[LN_GWAKE] && reg_wdata[GWAKE_BIT]);
      pdn_clr  = reg_wr && (sel == SEL_EVT) && reg_wstrb[LN_PDN] && reg_wdata[PDN_BIT];
      wake_set = wake_q && pmen_q;
   end

   // Enable bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pmen_q <= 1'b0;
      else if (pmen_we) pmen_q <= pmen_val;
   end

   // Coupled wake status pair: either clear source clears both
   cbw_sticky #(.SET_WINS(1'b1)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wake_set),
      .clr_i (wake_clr),
      .q_o   (sts_q)
   );

   cbw_sticky #(.SET_WINS(1'b1)) u_gwake (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wake_set),
      .clr_i (wake_clr),
      .q_o   (gwake_q)
   );

   cbw_sticky #(.SET_WINS(1'b1)) u_pdn (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (pdn_q),
      .clr_i (pdn_clr),
      .q_o   (pdn_evt_q)
   );

   // Mask bits; the wake masks follow every enable write
   generate
      for (genvar i = 0; i < N_MSK; i++) begin : g_msk
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (MSK_FOLLOW[i] && pmen_we)
               q <= pmen_val;
            else if (reg_wr && (sel == SEL_MSK) && reg_wstrb[MSK_POS[i] / 8])
               q <= reg_wdata[MSK_POS[i]];
         end
         assign msk_q[i] = q;
      end
   endgenerate

   // Read mux
   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_PM: begin
            reg_rdata[PMEN_BIT]  = pmen_q;
            reg_rdata[PMSTS_BIT] = sts_q;
         end
         SEL_EVT: begin
            reg_rdata[GWAKE_BIT] = gwake_q;
            reg_rdata[PDN_BIT]   = pdn_evt_q;
         end
         SEL_MSK: begin
            for (int i = 0; i < N_MSK; i++) reg_rdata[MSK_POS[i]] = msk_q[i];
         end
         SEL_NONE: reg_rdata = '0;
      endcase
   end

   always_comb begin
      st_o.pme_en    = pmen_q;
      st_o.pme_sts   = sts_q;
      st_o.gwake_evt = gwake_q;
      st_o.pdn_evt   = pdn_evt_q;
      st_o.msk_gwake = msk_q[0];
      st_o.msk_wkup  = msk_q[1];
      st_o.msk_pdn   = msk_q[2];
   end

   assign unused_bits = ^{reg_wdata, reg_wstrb, STRB_W[0]};

endmodule

// File: rtl/cbw_outs.sv
`timescale 1ns/1ps
// Output stage: bypass or card-side gating, mode steering, output registers.
module cbw_outs
   import cbw_pkg::*;
#(
   parameter bit GATE_IN_PCI = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_cardbus,
   input  logic       stsreg_en,
   input  cbw_state_t st_i,
   input  logic       pdn_q,
   output logic       pme_req,
   output logic       sysevt_req,
   output logic       card_int
);

   logic gate_on;
   logic wake_byp;
   logic wake_gated;
   logic wake_any;
   logic int_any;

   generate
      if (GATE_IN_PCI) begin : g_gate_any
         assign gate_on = stsreg_en;
      end else begin : g_gate_cb
         assign gate_on = stsreg_en && mode_cardbus;
      end
   endgenerate

   always_comb begin
      wake_byp   = st_i.pme_en && st_i.pme_sts;
      wake_gated = st_i.msk_gwake && st_i.msk_wkup && st_i.gwake_evt;
      wake_any   = gate_on ? wake_gated : wake_byp;
      int_any    = gate_on ? (st_i.msk_pdn && st_i.pdn_evt) : pdn_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pme_req    <= 1'b0;
         sysevt_req <= 1'b0;
         card_int   <= 1'b0;
      end else begin
         pme_req    <= wake_any && !mode_cardbus;
         sysevt_req <= wake_any &&  mode_cardbus;
         card_int   <= int_any;
      end
   end

endmodule

// File: rtl/cb_wake_ctrl.sv
`timescale 1ns/1ps
module cb_wake_ctrl
   import cbw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int ADDR_PM   = 0,
   parameter int ADDR_EVT  = 1,
   parameter int ADDR_MSK  = 2,
   parameter int PMEN_BIT  = 0,
   parameter int PMSTS_BIT = 1,
   parameter int GWAKE_BIT = 4,
   parameter int WKUP_BIT  = 14,
   parameter int PDN_BIT   = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [DATA_W/8-1:0] reg_wstrb,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                mode_cardbus,
   input  logic                stsreg_en,
   input  logic                wake_req,
   input  logic                wake_local_en,
   input  logic                pdown_req,
   input  logic                pdown_local_en,
   output logic                pme_req,
   output logic                sysevt_req,
   output logic                card_int
);

   localparam int N_REGS = 3;

   // Elaboration checks on the parameter set
   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("cb_wake_ctrl: DATA_W must be a multiple of 8 and at least 16");
      end
      if ((1 << ADDR_W) < N_REGS) begin : g_bad_addr
         $error("cb_wake_ctrl: ADDR_W too small for the register set");
      end
      if (PMEN_BIT >= DATA_W || PMSTS_BIT >= DATA_W || GWAKE_BIT >= DATA_W ||
          WKUP_BIT >= DATA_W || PDN_BIT >= DATA_W) begin : g_bad_bit
         $error("cb_wake_ctrl: a field position lies outside the data word");
      end
      if (PMEN_BIT == PMSTS_BIT || GWAKE_BIT == PDN_BIT ||
          GWAKE_BIT == WKUP_BIT || WKUP_BIT == PDN_BIT) begin : g_bad_overlap
         $error("cb_wake_ctrl: two fields share a bit position");
      end
      if (ADDR_PM == ADDR_EVT || ADDR_PM == ADDR_MSK || ADDR_EVT == ADDR_MSK) begin : g_bad_map
         $error("cb_wake_ctrl: register addresses collide");
      end
   endgenerate

   cbw_state_t st;
   logic       wake_q;
   logic       pdn_q;

   // State views for the bound checker
   logic st_pme_en, st_pme_sts, st_gwake, st_pdn_evt, st_msk_g, st_msk_w, st_msk_i;

   assign wake_q = wake_req  && wake_local_en;
   assign pdn_q  = pdown_req && pdown_local_en;

   cbw_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .ADDR_PM   (ADDR_PM),
      .ADDR_EVT  (ADDR_EVT),
      .ADDR_MSK  (ADDR_MSK),
      .PMEN_BIT  (PMEN_BIT),
      .PMSTS_BIT (PMSTS_BIT),
      .GWAKE_BIT (GWAKE_BIT),
      .WKUP_BIT  (WKUP_BIT),
      .PDN_BIT   (PDN_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wstrb (reg_wstrb),
      .reg_rdata (reg_rdata),
      .wake_q    (wake_q),
      .pdn_q     (pdn_q),
      .st_o      (st)
   );

   cbw_outs #(
      .GATE_IN_PCI (1'b0)
   ) u_outs (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_cardbus (mode_cardbus),
      .stsreg_en    (stsreg_en),
      .st_i         (st),
      .pdn_q        (pdn_q),
      .pme_req      (pme_req),
      .sysevt_req   (sysevt_req),
      .card_int     (card_int)
   );

   assign st_pme_en  = st.pme_en;
   assign st_pme_sts = st.pme_sts;
   assign st_gwake   = st.gwake_evt;
   assign st_pdn_evt = st.pdn_evt;
   assign st_msk_g   = st.msk_gwake;
   assign st_msk_w   = st.msk_wkup;
   assign st_msk_i   = st.msk_pdn;

endmodule

// File: rtl/cbw_checker.sv
`timescale 1ns/1ps
module cbw_checker #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter int ADDR_PM  = 0,
   parameter int ADDR_MSK = 2,
   parameter int PMEN_BIT = 0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [DATA_W/8-1:0] reg_wstrb,
   input logic                mode_cardbus,
   input logic                stsreg_en,
   input logic                wake_req,
   input logic                wake_local_en,
   input logic                pme_req,
   input logic                sysevt_req,
   input logic                card_int,
   input logic                st_pme_en,
   input logic                st_pme_sts,
   input logic                st_gwake,
   input logic                st_pdn_evt,
   input logic                st_msk_g,
   input logic                st_msk_w,
   input logic                st_msk_i
);

   logic unused_strb;
   assign unused_strb = ^reg_wstrb;

   assert_mask_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(ADDR_PM) && reg_wstrb[PMEN_BIT/8])
      |=> (st_msk_g == st_pme_en) && (st_msk_w == st_pme_en));

   assert_mask_keeps_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(ADDR_MSK)) |=> $stable(st_pme_en));

   // R4 and R6: a pending qualified wake always lands, whatever write is present
   assert_wake_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pme_en && wake_req && wake_local_en) |=> (st_pme_sts && st_gwake));

   assert_pair_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_pme_sts == st_gwake);

   assert_no_unqualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_pme_sts && !(wake_req && wake_local_en)) |=> !st_pme_sts);

   assert_gated_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sysevt_req && $past(stsreg_en)) |-> $past(st_msk_g && st_msk_w && st_gwake));

   assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(pme_req && sysevt_req));

   assert_pme_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pme_req |-> !$past(mode_cardbus));

   assert_sysevt_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sysevt_req |-> $past(mode_cardbus));

   assert_gated_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (card_int && $past(mode_cardbus && stsreg_en)) |-> $past(st_msk_i && st_pdn_evt));

endmodule

bind cb_wake_ctrl cbw_checker #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .ADDR_PM  (ADDR_PM),
   .ADDR_MSK (ADDR_MSK),
   .PMEN_BIT (PMEN_BIT)
) u_chk (.*);

// File: tb/cb_wake_ctrl_bench.sv
`timescale 1ns/1ps
module cb_wake_ctrl_bench;

   localparam int DW = 16;
   localparam int AW = 2;
   localparam int SW = DW / 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [SW-1:0] reg_wstrb = '0;
   logic [DW-1:0] reg_rdata;
   logic          mode_cardbus = 1'b0;
   logic          stsreg_en = 1'b0;
   logic          wake_req = 1'b0;
   logic          wake_local_en = 1'b0;
   logic          pdown_req = 1'b0;
   logic          pdown_local_en = 1'b0;
   logic          pme_req;
   logic          sysevt_req;
   logic          card_int;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cb_wake_ctrl u_cb_wake_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_wr         (reg_wr),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .reg_wstrb      (reg_wstrb),
      .reg_rdata      (reg_rdata),
      .mode_cardbus   (mode_cardbus),
      .stsreg_en      (stsreg_en),
      .wake_req       (wake_req),
      .wake_local_en  (wake_local_en),
      .pdown_req      (pdown_req),
      .pdown_local_en (pdown_local_en),
      .pme_req        (pme_req),
      .sysevt_req     (sysevt_req),
      .card_int       (card_int)
   );

   // Behavioural reference model
   bit m_en, m_sts, m_ev_wake, m_ev_pdn, m_mk_wake, m_mk_wkup, m_mk_pdn;
   bit m_pme, m_sys, m_int;

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      logic [DW-1:0] r;
      r = '0;
      case (a)
         2'd0: begin r[0] = m_en; r[1] = m_sts; end
         2'd1: begin r[4] = m_ev_wake; r[15] = m_ev_pdn; end
         2'd2: begin r[4] = m_mk_wake; r[14] = m_mk_wkup; r[15] = m_mk_pdn; end
         default: r = '0;
      endcase
      return r;
   endfunction

   always @(posedge clk) begin
      bit wq, pq, gate, w, clr, en_wr;
      if (!rst_n) begin
         m_en = 0; m_sts = 0; m_ev_wake = 0; m_ev_pdn = 0;
         m_mk_wake = 0; m_mk_wkup = 0; m_mk_pdn = 0;
         m_pme = 0; m_sys = 0; m_int = 0;
      end else begin
         wq   = wake_req && wake_local_en;
         pq   = pdown_req && pdown_local_en;
         gate = mode_cardbus && stsreg_en;
         w    = gate ? (m_mk_wake && m_mk_wkup && m_ev_wake) : (m_en && m_sts);
         m_pme = w && !mode_cardbus;
         m_sys = w && mode_cardbus;
         m_int = gate ? (m_mk_pdn && m_ev_pdn) : pq;
         clr   = reg_wr && reg_wstrb[0] &&
                 ((reg_addr == 2'd0 && reg_wdata[1]) || (reg_addr == 2'd1 && reg_wdata[4]));
         en_wr = reg_wr && reg_addr == 2'd0 && reg_wstrb[0];
         if (wq && m_en) begin m_sts = 1; m_ev_wake = 1; end
         else if (clr)   begin m_sts = 0; m_ev_wake = 0; end
         if (pq) m_ev_pdn = 1;
         else if (reg_wr && reg_addr == 2'd1 && reg_wstrb[1] && reg_wdata[15]) m_ev_pdn = 0;
         if (en_wr) begin
            m_en = reg_wdata[0]; m_mk_wake = reg_wdata[0]; m_mk_wkup = reg_wdata[0];
         end
         if (reg_wr && reg_addr == 2'd2) begin
            if (reg_wstrb[0]) m_mk_wake = reg_wdata[4];
            if (reg_wstrb[1]) begin m_mk_wkup = reg_wdata[14]; m_mk_pdn = reg_wdata[15]; end
         end
      end
   end

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Cycle-by-cycle comparison, away from both clock edges
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(DW'(pme_req),    DW'(m_pme), "R7 pme_req vs model");
         chk(DW'(sysevt_req), DW'(m_sys), "R8 sysevt_req vs model");
         chk(DW'(card_int),   DW'(m_int), "R10 card_int vs model");
         chk(reg_rdata, model_read(reg_addr), "R11 reg_rdata vs model");
         chk(DW'(pme_req && sysevt_req), '0, "R9 both wake outputs active");
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
      @(negedge clk);
      reg_wr = 1'b0; reg_wstrb = '0;
   endtask

   task automatic rdchk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      chk(reg_rdata, exp, tag);
   endtask

   task automatic wake_pulse();
      @(negedge clk);
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      wake_local_en = 1'b1;
      pdown_local_en = 1'b1;

      // R1 reset state
      rdchk(2'd0, 16'h0000, "R1 power control after reset");
      rdchk(2'd1, 16'h0000, "R1 events after reset");
      rdchk(2'd2, 16'h0000, "R1 masks after reset");
      chk(DW'({pme_req, sysevt_req, card_int}), '0, "R1 outputs after reset");

      // R2 enable drives both wake masks
      wr(2'd0, 16'h0001, 2'b01);
      rdchk(2'd2, 16'h4010, "R2 masks follow enable set");
      rdchk(2'd0, 16'h0001, "R2 enable set");
      // R3 mask write leaves enable
      wr(2'd2, 16'h0000, 2'b11);
      rdchk(2'd0, 16'h0001, "R3 enable kept after mask clear");
      rdchk(2'd2, 16'h0000, "R3 masks cleared");
      wr(2'd0, 16'h0001, 2'b01);
      wr(2'd0, 16'h0000, 2'b01);
      rdchk(2'd2, 16'h0000, "R2 masks follow enable clear");
      wr(2'd0, 16'h0001, 2'b01);

      // R12 unqualified wake ignored
      wake_local_en = 1'b0;
      wake_pulse();
      rdchk(2'd0, 16'h0001, "R12 wake without local enable");
      chk(DW'(pme_req), '0, "R12 no wake output");
      wake_local_en = 1'b1;

      // R4 latch, R7 bypass output in PCI mode
      wake_pulse();
      rdchk(2'd0, 16'h0003, "R4 status latched");
      rdchk(2'd1, 16'h0010, "R4 event latched");
      chk(DW'(pme_req), 1, "R7 pme_req asserted");
      chk(DW'(sysevt_req), 0, "R9 sysevt_req idle in PCI mode");

      // R5 write zero, then write one clears both
      wr(2'd1, 16'h0000, 2'b11);
      rdchk(2'd0, 16'h0003, "R5 zero write has no effect");
      wr(2'd1, 16'h0010, 2'b11);
      rdchk(2'd0, 16'h0001, "R5 event clear also clears status");
      rdchk(2'd1, 16'h0000, "R5 event cleared");
      chk(DW'(pme_req), 0, "R7 pme_req released");

      // R6 event wins over clear in the same cycle
      @(negedge clk);
      wake_req = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0003; reg_wstrb = 2'b01;
      @(negedge clk);
      wake_req = 1'b0; reg_wr = 1'b0; reg_wstrb = '0;
      rdchk(2'd0, 16'h0003, "R6 set wins over clear");

      // R11 byte lanes
      wr(2'd0, 16'h0002, 2'b10);
      rdchk(2'd0, 16'h0003, "R11 unstrobed lane kept");
      wr(2'd0, 16'h0003, 2'b01);
      rdchk(2'd0, 16'h0001, "R11 strobed lane cleared");
      wr(2'd2, 16'hC000, 2'b01);
      rdchk(2'd2, 16'h4000, "R11 mask upper lane kept");

      // R8 gated CardBus wake
      wr(2'd0, 16'h0001, 2'b01);
      mode_cardbus = 1'b1; stsreg_en = 1'b1;
      wake_pulse();
      rdchk(2'd0, 16'h0003, "R8 status set");
      chk(DW'(sysevt_req), 1, "R8 gated wake asserted");
      chk(DW'(pme_req), 0, "R9 pme_req idle in CardBus mode");
      wr(2'd2, 16'h0010, 2'b11);
      rdchk(2'd0, 16'h0003, "R3 enable kept after mask write");
      chk(DW'(sysevt_req), 0, "R8 wake blocked by mask");
      @(negedge clk); stsreg_en = 1'b0;
      @(negedge clk); #0.5;
      chk(DW'(sysevt_req), 1, "R7 bypass in CardBus mode");
      @(negedge clk); mode_cardbus = 1'b0;
      @(negedge clk); #0.5;
      chk(DW'(pme_req), 1, "R9 pme_req after switch to PCI");
      chk(DW'(sysevt_req), 0, "R9 sysevt_req after switch to PCI");
      wr(2'd0, 16'h0003, 2'b01);

      // R10 powerdown gating
      @(negedge clk); mode_cardbus = 1'b1; stsreg_en = 1'b1;
      @(negedge clk); pdown_req = 1'b1;
      @(negedge clk); pdown_req = 1'b0;
      rdchk(2'd1, 16'h8000, "R10 powerdown event latched");
      chk(DW'(card_int), 0, "R10 interrupt masked");
      wr(2'd2, 16'h8000, 2'b10);
      rdchk(2'd2, 16'h8010, "R10 mask set");
      chk(DW'(card_int), 1, "R10 interrupt unmasked");
      wr(2'd1, 16'h8000, 2'b10);
      rdchk(2'd1, 16'h0000, "R10 event cleared");
      chk(DW'(card_int), 0, "R10 interrupt released");
      @(negedge clk); stsreg_en = 1'b0; pdown_req = 1'b1;
      @(negedge clk); #0.5;
      chk(DW'(card_int), 1, "R10 bypass follows request");
      @(negedge clk); pdown_req = 1'b0; pdown_local_en = 1'b0;
      @(negedge clk); #0.5;
      chk(DW'(card_int), 0, "R10 bypass release");
      @(negedge clk); pdown_req = 1'b1;
      @(negedge clk); #0.5;
      chk(DW'(card_int), 0, "R12 unqualified powerdown ignored");
      pdown_req = 1'b0;

      // Random phase against the model
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         reg_wr         = ($urandom_range(0, 3) == 0);
         reg_addr       = AW'($urandom_range(0, 3));
         reg_wdata      = DW'($urandom);
         reg_wstrb      = SW'($urandom_range(0, 3));
         wake_req       = ($urandom_range(0, 5) == 0);
         wake_local_en  = ($urandom_range(0, 3) != 0);
         pdown_req      = ($urandom_range(0, 5) == 0);
         pdown_local_en = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 31) == 0) mode_cardbus = ~mode_cardbus;
         if ($urandom_range(0, 31) == 0) stsreg_en = ~stsreg_en;
      end
      @(negedge clk);
      reg_wr = 1'b0; wake_req = 1'b0; pdown_req = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule